// File: doc/BRIEF.md
# Mixed-Radix Residue-to-Binary Converter

This block turns a three-channel residue number back into an ordinary unsigned binary integer. The channels use the pairwise coprime moduli m1 = 2^N − 1, m2 = 2^(2N) and m3 = 2^(2N+1) − 1. Their product M = m1·m2·m3 is the dynamic range, and every integer in [0, M − 1] converts exactly, including the top of the range.

The conversion follows the mixed-radix route. The first digit is the m1 residue itself. The second digit is a plain modulo-2^(2N) sum of three shifted or inverted operands. The third digit is a modulo-(2^(2N+1) − 1) sum of four rotated or complemented operands, reduced with end-around carries. The three digits are then recombined as X = a1 + a2·m1 + a3·m1·m2. This recombination adds one concatenation and two complemented operands in a carry-save stage followed by a single wide adder. No multiplier and no table is used.

Residues enter on a valid/ready stream and the binary value leaves on another. A single output register sits between the two. A new residue is taken whenever the register is empty or is being drained in the same cycle. When the consumer holds `out_ready` low, the register keeps its value and `in_ready` falls, so back-pressure reaches the producer in the same cycle with no extra storage.

Top module: `rns_mrc_conv`

## Requirements
- R1: The low 2N bits of `out_value` equal the `res_m2` residue of the accepted input (X mod 2^(2N)).
- R2: `out_value` mod (2^N − 1) equals the accepted `res_m1`.
- R3: `out_value` mod (2^(2N+1) − 1) equals the accepted `res_m3`.
- R4: For canonical residues of any integer X in [0, M − 1], `out_value` equals X, and it is always below M.
- R5: The third mixed-radix digit is kept in [0, m3 − 1]. An all-ones modular sum is mapped to zero, so every X below m1·m2 converts exactly.
- R6: While `rst_n` is low, and in the first cycle after it rises, `out_valid` is 0 and `in_ready` is 1.
- R7: An input taken on a clock edge (`in_valid` and `in_ready` both 1) appears on `out_value` with `out_valid` = 1 right after that edge, one cycle of latency.
- R8: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0, and `out_valid` and `out_value` hold through the next edge.
- R9: `in_ready` is 1 whenever the output register is empty or `out_ready` is 1.
- R10: When the register is free and `in_valid` is 0 at an edge, `out_valid` is 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Residue triple present |
| in_ready | output | 1 | Converter can take a residue triple this cycle |
| res_m1 | input | N | Residue modulo 2^N − 1, in [0, 2^N − 2] |
| res_m2 | input | 2N | Residue modulo 2^(2N) |
| res_m3 | input | 2N+1 | Residue modulo 2^(2N+1) − 1, in [0, 2^(2N+1) − 2] |
| out_valid | output | 1 | Converted value present |
| out_ready | input | 1 | Consumer takes the converted value this cycle |
| out_value | output | 5N+1 | Binary integer X in [0, M − 1] |

## Verification
The assertions assume canonical residues whenever `in_valid` is high. In that case `res_m1` is never all ones and `res_m3` is never all ones. Both all-ones codes are aliases of zero, and an aliased input could break the range and residue properties even though the modular arithmetic would stay consistent. The stimulus keeps to this rule because it builds every residue triple from a generating integer with the modulo operator. It sweeps every integer of the N = 3 range in rising order, so the bottom, the top and every digit boundary are reached. Random bubbles on `in_valid` and random and periodic stalls on `out_ready` exercise the handshake rules.

// File: rtl/rns_mrc_pkg.sv
package rns_mrc_pkg;
  // Width of the power-of-two channel (2N bits)
  function automatic int bin_w(input int n);
    return 2 * n;
  endfunction
  // Width of the 2^(2N+1)-1 channel
  function automatic int mer_w(input int n);
    return 2 * n + 1;
  endfunction
  // Width of the binary result, covers M-1
  function automatic int res_w(input int n);
    return 5 * n + 1;
  endfunction
endpackage

// File: rtl/rns_csa.sv
// Three-operand carry-save layer. END_AROUND selects a modulo 2^W-1 layer
// (carry out of the top re-enters at bit 0) or a modulo 2^W layer
// (carry out dropped, bit 0 of the carry word is zero).
module rns_csa #(
  parameter int W          = 8,
  parameter bit END_AROUND = 1'b0
) (
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic [W-1:0] op_c,
  output logic [W-1:0] sum_o,
  output logic [W-1:0] cy_o
);
  logic [W-1:0] maj;

  assign sum_o = op_a ^ op_b ^ op_c;
  assign maj   = (op_a & op_b) | (op_a & op_c) | (op_b & op_c);

  generate
    if (END_AROUND) begin : g_eac
      assign cy_o = {maj[W-2:0], maj[W-1]};
    end else begin : g_trunc
      assign cy_o = {maj[W-2:0], 1'b0};
    end
  endgenerate
endmodule

// File: rtl/rns_mrc_digit2.sv
// Second mixed-radix digit: (2^N*r1 + r1 - 2^N*r2 - r2) mod 2^(2N).
// Both negations are one's complements plus one; the two +1 go into the final add.
module rns_mrc_digit2 #(
  parameter int N = 4
) (
  input  logic [N-1:0]   res_m1,
  input  logic [2*N-1:0] res_m2,
  output logic [2*N-1:0] digit_o
);
  localparam int W = rns_mrc_pkg::bin_w(N);

  logic [W-1:0] t_pair, t_shift, t_plain, s_w, c_w;

  assign t_pair  = {res_m1, res_m1};
  assign t_shift = {~res_m2[N-1:0], {N{1'b1}}};
  assign t_plain = ~res_m2;

  rns_csa #(.W(W), .END_AROUND(1'b0)) u_layer (
    .op_a (t_pair),
    .op_b (t_shift),
    .op_c (t_plain),
    .sum_o(s_w),
    .cy_o (c_w)
  );

  assign digit_o = s_w + c_w + W'(2);
endmodule

// File: rtl/rns_mrc_digit3.sv
// Third mixed-radix digit modulo 2^(2N+1)-1:
// -2^(N+2)*r3 - 4*r3 + 4*{r1,r1} - 2*a2, built from rotations and complements.
module rns_mrc_digit3 #(
  parameter int N = 4
) (
  input  logic [N-1:0]   res_m1,
  input  logic [2*N:0]   res_m3,
  input  logic [2*N-1:0] digit2,
  output logic [2*N:0]   digit_o
);
  localparam int W = rns_mrc_pkg::mer_w(N);
  localparam int R = N + 2;

  logic [W-1:0] t_far, t_near, t_pos, t_prev, pair;
  logic [W-1:0] s1, c1, s2, c2, folded;
  logic [W:0]   raw;

  assign t_far  = ~{res_m3[W-1-R:0], res_m3[W-1:W-R]};
  assign t_near = ~{res_m3[W-3:0], res_m3[W-1:W-2]};
  assign pair   = {1'b0, res_m1, res_m1};
  assign t_pos  = {pair[W-3:0], pair[W-1:W-2]};
  assign t_prev = {~digit2, 1'b1};

  rns_csa #(.W(W), .END_AROUND(1'b1)) u_lvl1 (
    .op_a (t_far),
    .op_b (t_near),
    .op_c (t_pos),
    .sum_o(s1),
    .cy_o (c1)
  );

  rns_csa #(.W(W), .END_AROUND(1'b1)) u_lvl2 (
    .op_a (s1),
    .op_b (c1),
    .op_c (t_prev),
    .sum_o(s2),
    .cy_o (c2)
  );

  // One's-complement adder: fold the carry back once, then clear the
  // all-ones alias of zero.
  assign raw     = {1'b0, s2} + {1'b0, c2};
  assign folded  = raw[W-1:0] + {{(W-1){1'b0}}, raw[W]};
  assign digit_o = (&folded) ? '0 : folded;
endmodule

// File: rtl/rns_mrc_combine.sv
// X = a1 + a2*(2^N-1) + a3*2^(2N)*(2^N-1)
//   = {a3,a2,a1} - 2^(2N)*a3 - a2  (mod 2^(5N+1))
module rns_mrc_combine #(
  parameter int N = 4
) (
  input  logic [N-1:0]   digit1,
  input  logic [2*N-1:0] digit2,
  input  logic [2*N:0]   digit3,
  output logic [5*N:0]   value_o
);
  localparam int XW = rns_mrc_pkg::res_w(N);

  logic [XW-1:0] t_cat, t_neg3, t_neg2, s_w, c_w;

  assign t_cat  = {digit3, digit2, digit1};
  assign t_neg3 = {{N{1'b1}}, ~digit3, {(2*N){1'b1}}};
  assign t_neg2 = {{(3*N+1){1'b1}}, ~digit2};

  rns_csa #(.W(XW), .END_AROUND(1'b0)) u_layer (
    .op_a (t_cat),
    .op_b (t_neg3),
    .op_c (t_neg2),
    .sum_o(s_w),
    .cy_o (c_w)
  );

  // Two complemented operands each owe +1
  assign value_o = s_w + c_w + XW'(2);
endmodule

// File: rtl/rns_mrc_conv.sv
module rns_mrc_conv #(
  parameter int N = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [N-1:0]   res_m1,
  input  logic [2*N-1:0] res_m2,
  input  logic [2*N:0]   res_m3,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [5*N:0]   out_value
);
  localparam int W2 = rns_mrc_pkg::bin_w(N);
  localparam int W3 = rns_mrc_pkg::mer_w(N);
  localparam int XW = rns_mrc_pkg::res_w(N);

  logic [W2-1:0] digit_mid;
  logic [W3-1:0] digit_hi;
  logic [XW-1:0] conv_value;
  logic          hold_valid;
  logic [XW-1:0] hold_value;

  rns_mrc_digit2 #(.N(N)) u_digit2 (
    .res_m1 (res_m1),
    .res_m2 (res_m2),
    .digit_o(digit_mid)
  );

  rns_mrc_digit3 #(.N(N)) u_digit3 (
    .res_m1 (res_m1),
    .res_m3 (res_m3),
    .digit2 (digit_mid),
    .digit_o(digit_hi)
  );

  rns_mrc_combine #(.N(N)) u_combine (
    .digit1 (res_m1),
    .digit2 (digit_mid),
    .digit3 (digit_hi),
    .value_o(conv_value)
  );

  // Single-entry output stage: refills in the cycle it drains
  assign in_ready = !hold_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_valid <= 1'b0;
      hold_value <= '0;
    end else if (in_ready) begin
      hold_valid <= in_valid;
      if (in_valid) hold_value <= conv_value;
    end
  end

  assign out_valid = hold_valid;
  assign out_value = hold_value;
endmodule

// File: rtl/rns_mrc_conv_chk.sv
module rns_mrc_conv_chk #(
  parameter int N = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_valid,
  input logic           in_ready,
  input logic [N-1:0]   res_m1,
  input logic [2*N-1:0] res_m2,
  input logic [2*N:0]   res_m3,
  input logic           out_valid,
  input logic           out_ready,
  input logic [5*N:0]   out_value,
  input logic [2*N:0]   digit_hi
);
  localparam longint unsigned M1 = (64'd1 << N) - 64'd1;
  localparam longint unsigned M2 = 64'd1 << (2 * N);
  localparam longint unsigned M3 = (64'd1 << (2 * N + 1)) - 64'd1;
  localparam longint unsigned MT = M1 * M2 * M3;

  logic [N-1:0]   cap_m1;
  logic [2*N-1:0] cap_m2;
  logic [2*N:0]   cap_m3;
  logic [63:0]    wide_out;

  assign wide_out = 64'(out_value);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_m1 <= '0;
      cap_m2 <= '0;
      cap_m3 <= '0;
    end else if (in_valid && in_ready) begin
      cap_m1 <= res_m1;
      cap_m2 <= res_m2;
      cap_m3 <= res_m3;
    end
  end

  // Input contract: canonical residues only
  assert_canonical_in_R4: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> (res_m1 != '1) && (res_m3 != '1));

  assert_low_bits_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_value[2*N-1:0] == cap_m2);

  assert_mod_m1_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (wide_out % M1) == 64'(cap_m1));

  assert_mod_m3_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (wide_out % M3) == 64'(cap_m3));

  assert_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> wide_out < MT);

  assert_digit_norm_R5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> digit_hi != '1);

  assert_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_value));

  assert_block_input_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  assert_ready_free_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  assert_bubble_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid && in_ready |=> !out_valid);
endmodule

bind rns_mrc_conv rns_mrc_conv_chk #(.N(N)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .res_m1   (res_m1),
  .res_m2   (res_m2),
  .res_m3   (res_m3),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_value(out_value),
  .digit_hi (digit_hi)
);

// File: tb/rns_mrc_conv_tb_top.sv
module rns_mrc_conv_tb_top;
  localparam int N  = 3;
  localparam int W1 = N;
  localparam int W2 = 2 * N;
  localparam int W3 = 2 * N + 1;
  localparam int XW = 5 * N + 1;
  localparam int M1 = (1 << N) - 1;
  localparam int M2 = 1 << (2 * N);
  localparam int M3 = (1 << (2 * N + 1)) - 1;
  localparam int MT = M1 * M2 * M3;
  localparam int WATCHDOG = 190000;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid;
  logic          in_ready;
  logic [W1-1:0] res_m1;
  logic [W2-1:0] res_m2;
  logic [W3-1:0] res_m3;
  logic          out_valid;
  logic          out_ready;
  logic [XW-1:0] out_value;

  always #4 clk = ~clk;

  rns_mrc_conv #(.N(N)) dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .res_m1   (res_m1),
    .res_m2   (res_m2),
    .res_m3   (res_m3),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_value(out_value)
  );

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  bit run    = 1'b0;
  int drv_x  = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Behavioural model of the single output slot
  logic mv;
  int   mx;
  always @(posedge clk) begin
    if (!rst_n) begin
      mv <= 1'b0;
      mx <= 0;
    end else if (!mv || out_ready) begin
      mv <= in_valid;
      if (in_valid) mx <= drv_x;
    end
  end

  // Compare on the falling edge, away from the active edge
  always @(negedge clk) begin
    if (run) begin
      check(out_valid == mv, mv ? "R7 output valid" : "R10 output idle",
            longint'(out_valid), longint'(mv));
      check(in_ready == (!mv || out_ready), (mv && !out_ready) ? "R8 input blocked" : "R9 input open",
            longint'(in_ready), longint'(!mv || out_ready));
      if (mv && out_valid) begin
        check(int'(out_value) == mx, (mv && !out_ready) ? "R8 held value" : "R4 value",
              longint'(out_value), longint'(mx));
        check(int'(out_value[W2-1:0]) == (mx % M2), "R1 low bits",
              longint'(out_value[W2-1:0]), longint'(mx % M2));
        check((int'(out_value) % M1) == (mx % M1), "R2 mod m1",
              longint'(int'(out_value) % M1), longint'(mx % M1));
        check((int'(out_value) % M3) == (mx % M3), "R3 mod m3",
              longint'(int'(out_value) % M3), longint'(mx % M3));
        if (mx < M1 * M2)
          check(int'(out_value) == mx, "R5 zero top digit",
                longint'(out_value), longint'(mx));
      end
    end
  end

  // Consumer: periodic stall windows plus random stalls
  always begin
    @(posedge clk);
    #1;
    out_ready = ((cyc % 64) < 6) ? 1'b0 : (($urandom % 4) != 0);
  end

  // Watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      errors++;
      $display("FAIL R7 watchdog: actual %0d cycles expected below %0d", cyc, WATCHDOG);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic drive_residues(input int x);
    drv_x  = x;
    res_m1 = W1'(x % M1);
    res_m2 = W2'(x % M2);
    res_m3 = W3'(x % M3);
  endtask

  initial begin
    bit hs;
    rst_n     = 1'b0;
    in_valid  = 1'b0;
    out_ready = 1'b0;
    drive_residues(0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(out_valid == 1'b0, "R6 reset valid", longint'(out_valid), 0);
    check(in_ready == 1'b1, "R6 reset ready", longint'(in_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R6 after release", longint'(out_valid), 0);
    @(posedge clk);
    #1;
    run = 1'b1;

    // Exhaustive rising sweep of the whole range
    for (int x = 0; x < MT; x++) begin
      if (($urandom % 8) == 0) begin
        in_valid = 1'b0;
        @(posedge clk);
        #1;
      end
      drive_residues(x);
      in_valid = 1'b1;
      do begin
        @(negedge clk);
        hs = in_valid && in_ready;
        @(posedge clk);
        #1;
      end while (!hs);
    end
    in_valid = 1'b0;

    // Drain the slot
    repeat (80) begin
      @(posedge clk);
      #1;
    end
    @(negedge clk);
    check(out_valid == 1'b0, "R10 drained", longint'(out_valid), 0);
    run = 1'b0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule